// File: doc/BRIEF.md
# Per-Sample Microprogram DSP Core

This core executes a fixed list of microinstructions, one per clock, and repeats the whole list for each audio sample. The output sample rate is therefore the clock rate divided by the list length. At the default length of 512, a 40 MHz clock gives 78125 samples per second.

Each 64-bit microinstruction does four things in one cycle. It gathers operands from two operand banks or from an external-memory read port. It routes two of them into a saturating adder/multiplier unit. It computes a result. It then writes that result back to bank A, bank B or the external port.

A single accumulator register holds the most recent result. It also serves as the running sum for multiply-accumulate. When the list wraps, the core does three things:
- it raises a one-cycle sample strobe;
- it stores the incoming audio word in bank A;
- it presents a word from bank B as the audio output.

A host loads the microprogram through a write port while the run input is low.

Top module: `sl_sample_loop_core`

## Requirements
- R1: After reset the slot counter is 0. While `run` is high it advances by one each clock and returns to 0 after slot 511. While `run` is low it is forced to 0.
- R2: `sample_strobe` is high for exactly one cycle: the cycle after slot 511 executes. Under continuous running this repeats every 512 cycles.
- R3: On the clock edge that ends slot 511, `audio_in` is written into bank A address 0, and `audio_out` is loaded from bank B address 0. Address 0 in bank B is read before any write by slot 511. `audio_out` changes at no other edge.
- R4: Microinstruction field positions:
  - [63:55] bank-A read address;
  - [54:46] bank-B read address;
  - [45:37] write address;
  - [36:35] write target (0 none, 1 bank A, 2 bank B, 3 external);
  - [34:33] X source;
  - [32:31] Y source;
  - [30:28] operation;
  - [27:0] reserved, must be zero.
- R5: Source codes are 0 = bank A at the A address, 1 = bank B at the B address, 2 = external read data, 3 = accumulator. `ext_raddr` always carries the B address field of the executing slot.
- R6: Operation 0 (add) and operation 1 (subtract, X minus Y) saturate the 24-bit signed result to the range -8388608..8388607.
- R7: Operation 2 (multiply) returns the 48-bit product X*Y, arithmetically shifted right by 23 and saturated to 24 bits. Operation 3 (multiply-accumulate) returns the accumulator plus that scaled product, saturated. Operation 4 (and codes 5 to 7) passes X through.
- R8: Every executed result is stored in the accumulator. A bank write is visible to the next slot. An external write drives `ext_we`, `ext_waddr` and `ext_wdata` in the same cycle as the executing slot.
- R9: `prog_we` stores `prog_wdata` at `prog_addr` only while `run` is low. While `run` is low, no bank, accumulator or external write occurs and no strobe is raised.
- R10: Reset clears both banks, the accumulator, `audio_out` and `sample_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High to execute the microprogram; low to hold and load |
| prog_we | input | 1 | Microprogram write strobe |
| prog_addr | input | 9 | Microprogram slot to write |
| prog_wdata | input | 64 | Microinstruction to store |
| audio_in | input | 24 | Incoming audio word, stored at the wrap |
| audio_out | output | 24 | Outgoing audio word, updated at the wrap |
| sample_strobe | output | 1 | One-cycle pulse after each complete pass |
| ext_raddr | output | 9 | External read address |
| ext_rdata | input | 24 | External read data, used in the same cycle |
| ext_we | output | 1 | External write enable |
| ext_waddr | output | 9 | External write address |
| ext_wdata | output | 24 | External write data |

## Verification
The external port is combinational, so a result written there appears on `ext_wdata` in the same cycle as its slot. The bench therefore samples the port at the falling edge inside slots 4, 5 and 6 of each pass. `sample_strobe` and `audio_out` are registered at the edge that ends slot 511. They are sampled at the falling edge of the following cycle, where the bench's own slot count reads 0. The expected output there comes from the samples latched at the two previous wraps, because the program keeps one sample of history in bank A. After a run pause the count restarts at the first rising edge with `run` high, which matches the slot counter being forced to 0.

// File: rtl/sl_pkg.sv
// Shared encodings for the per-sample microprogram core.
// Assumes a 64-bit microinstruction whose fields are packed MSB first.
package sl_pkg;
    localparam int DATA_W  = 24;
    localparam int FRAC_W  = 23;
    localparam int ADDR_W  = 9;
    localparam int INSTR_W = 64;
    localparam int RSVD_W  = INSTR_W - 3*ADDR_W - 2 - 2 - 2 - 3;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_A    = 2'd1,
        DST_B    = 2'd2,
        DST_EXT  = 2'd3
    } dst_e;

    typedef enum logic [1:0] {
        SRC_A   = 2'd0,
        SRC_B   = 2'd1,
        SRC_EXT = 2'd2,
        SRC_ACC = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_MAC  = 3'd3,
        OP_PASS = 3'd4
    } op_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr_a;
        logic [ADDR_W-1:0] addr_b;
        logic [ADDR_W-1:0] addr_w;
        dst_e              dst;
        src_e              src_x;
        src_e              src_y;
        op_e               op;
        logic [RSVD_W-1:0] rsvd;
    } uinstr_t;
endpackage

// File: rtl/sl_seq_ctrl.sv
// Slot sequencer: steps a counter through SLOTS positions, one per clock.
// Assumes SLOTS is a power of two matching the counter width.
// Emits the wrap condition combinationally and a registered sample strobe.
module sl_seq_ctrl #(
    parameter int SLOTS = 512,
    parameter int PC_W  = $clog2(SLOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    output logic [PC_W-1:0] pc_o,
    output logic            wrap_o,
    output logic            strobe_o
);
    localparam logic [PC_W-1:0] LAST = PC_W'(SLOTS - 1);

    assign wrap_o = run_i && (pc_o == LAST);

    // Advance the slot counter; hold at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || wrap_o) begin
            pc_o <= '0;
        end else begin
            pc_o <= pc_o + 1'b1;
        end
    end

    // One-cycle strobe following the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_o <= 1'b0;
        end else begin
            strobe_o <= wrap_o;
        end
    end

    AST_PC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && pc_o == LAST) |=> (pc_o == '0)); // R1
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && pc_o != LAST) |=> (pc_o == $past(pc_o) + 1'b1)); // R1
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o); // R2
    AST_RUN_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (pc_o == '0 && !strobe_o)); // R9
endmodule

// File: rtl/sl_ucode_store.sv
// Microprogram store: a register array with one host write port and one
// asynchronous read port addressed by the slot counter.
// Assumes the host writes only while run is low; other writes are dropped.
module sl_ucode_store #(
    parameter int SLOTS = 512,
    parameter int AW    = $clog2(SLOTS),
    parameter int IW    = 64
) (
    input  logic          clk,
    input  logic          run_i,
    input  logic          host_we_i,
    input  logic [AW-1:0] host_addr_i,
    input  logic [IW-1:0] host_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [IW-1:0] rd_data_o
);
    logic [IW-1:0] words [SLOTS];

    // Accept host loads only while the core is stopped.
    always_ff @(posedge clk) begin
        if (host_we_i && !run_i) begin
            words[host_addr_i] <= host_data_i;
        end
    end

    assign rd_data_o = words[rd_addr_i];
endmodule

// File: rtl/sl_data_banks.sv
// Two operand banks with asynchronous reads, one shared write address and
// per-bank enables. Also provides the audio port: a fixed bank-A slot
// loaded at the wrap, and a fixed bank-B slot tapped for output.
// Assumes the audio load has priority over a same-edge bank-A write.
module sl_data_banks #(
    parameter int DEPTH    = 512,
    parameter int AW       = $clog2(DEPTH),
    parameter int DW       = 24,
    parameter int IN_SLOT  = 0,
    parameter int OUT_SLOT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr_a_i,
    input  logic [AW-1:0] rd_addr_b_i,
    output logic [DW-1:0] rd_a_o,
    output logic [DW-1:0] rd_b_o,
    input  logic          we_a_i,
    input  logic          we_b_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          audio_wr_i,
    input  logic [DW-1:0] audio_in_i,
    output logic [DW-1:0] audio_tap_o
);
    localparam logic [AW-1:0] IN_A  = AW'(IN_SLOT);
    localparam logic [AW-1:0] OUT_B = AW'(OUT_SLOT);

    logic [DW-1:0] bank_a [DEPTH];
    logic [DW-1:0] bank_b [DEPTH];

    // Bank A: clear on reset, result write, audio load last so it wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) bank_a[i] <= '0;
        end else begin
            if (we_a_i) bank_a[wr_addr_i] <= wr_data_i;
            if (audio_wr_i) bank_a[IN_A] <= audio_in_i;
        end
    end

    // Bank B: clear on reset, result write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) bank_b[i] <= '0;
        end else if (we_b_i) begin
            bank_b[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_a_o      = bank_a[rd_addr_a_i];
    assign rd_b_o      = bank_b[rd_addr_b_i];
    assign audio_tap_o = bank_b[OUT_B];

    AST_AUDIO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        audio_wr_i |=> (bank_a[IN_A] == $past(audio_in_i))); // R3
endmodule

// File: rtl/sl_func_unit.sv
// Functional unit: saturating add/subtract, fractional multiply with
// right shift and clip, multiply-accumulate, and pass-through.
// The accumulator captures every executed result.
// Assumes signed two's-complement data of DW bits with FRAC fraction bits.
module sl_func_unit
    import sl_pkg::*;
#(
    parameter int DW   = 24,
    parameter int FRAC = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  op_e                  op_i,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] y_i,
    output logic signed [DW-1:0] result_o,
    output logic signed [DW-1:0] acc_o
);
    localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [2*DW-1:0] WIDE_MAX = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [2*DW-1:0] WIDE_MIN = {{(DW+1){1'b1}}, {(DW-1){1'b0}}};

    // Clip a one-bit-wider sum back to DW bits.
    function automatic logic signed [DW-1:0] clip_narrow(input logic signed [DW:0] v);
        if (v[DW] != v[DW-1]) return v[DW] ? MINV : MAXV;
        return v[DW-1:0];
    endfunction

    // Clip a double-width value back to DW bits.
    function automatic logic signed [DW-1:0] clip_wide(input logic signed [2*DW-1:0] v);
        if (v > WIDE_MAX) return MAXV;
        if (v < WIDE_MIN) return MINV;
        return v[DW-1:0];
    endfunction

    logic signed [2*DW-1:0] product;
    logic signed [2*DW-1:0] shifted;
    logic signed [DW-1:0]   prod_q;
    logic signed [DW:0]     sum_w;
    logic signed [DW:0]     diff_w;
    logic signed [DW:0]     mac_w;

    // Arithmetic paths, all evaluated in parallel.
    always_comb begin
        product = (2*DW)'(x_i) * (2*DW)'(y_i);
        shifted = product >>> FRAC;
        prod_q  = clip_wide(shifted);
        sum_w   = {x_i[DW-1], x_i} + {y_i[DW-1], y_i};
        diff_w  = {x_i[DW-1], x_i} - {y_i[DW-1], y_i};
        mac_w   = {acc_o[DW-1], acc_o} + {prod_q[DW-1], prod_q};
    end

    // Result selection by operation code.
    always_comb begin
        case (op_i)
            OP_ADD:  result_o = clip_narrow(sum_w);
            OP_SUB:  result_o = clip_narrow(diff_w);
            OP_MUL:  result_o = prod_q;
            OP_MAC:  result_o = clip_narrow(mac_w);
            default: result_o = x_i;
        endcase
    end

    // Accumulator holds the latest executed result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else if (run_i) begin
            acc_o <= result_o;
        end
    end

    AST_MUL_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_MUL && !x_i[DW-1] && !y_i[DW-1]) |-> !result_o[DW-1]); // R7
    AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(acc_o)); // R9
endmodule

// File: rtl/sl_sample_loop_core.sv
// Per-sample microprogram core. Fetches the slot's microinstruction,
// selects operands from bank A, bank B, the external port or the
// accumulator, computes, and writes back; the audio exchange happens at
// the wrap. Assumes external read data is valid in the same cycle.
module sl_sample_loop_core
    import sl_pkg::*;
#(
    parameter int SLOTS    = 2**ADDR_W,
    parameter int IN_SLOT  = 0,
    parameter int OUT_SLOT = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               prog_we,
    input  logic [ADDR_W-1:0]  prog_addr,
    input  logic [INSTR_W-1:0] prog_wdata,
    input  logic [DATA_W-1:0]  audio_in,
    output logic [DATA_W-1:0]  audio_out,
    output logic               sample_strobe,
    output logic [ADDR_W-1:0]  ext_raddr,
    input  logic [DATA_W-1:0]  ext_rdata,
    output logic               ext_we,
    output logic [ADDR_W-1:0]  ext_waddr,
    output logic [DATA_W-1:0]  ext_wdata
);
    localparam int DW = DATA_W;
    localparam int AW = ADDR_W;

    logic [AW-1:0]        pc;
    logic                 wrap;
    logic [INSTR_W-1:0]   ins_raw;
    uinstr_t              ins;
    logic [DW-1:0]        rd_a;
    logic [DW-1:0]        rd_b;
    logic [DW-1:0]        tap;
    logic signed [DW-1:0] opx;
    logic signed [DW-1:0] opy;
    logic signed [DW-1:0] result;
    logic signed [DW-1:0] acc;
    logic                 we_a;
    logic                 we_b;

    sl_seq_ctrl #(.SLOTS(SLOTS), .PC_W(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .pc_o     (pc),
        .wrap_o   (wrap),
        .strobe_o (sample_strobe)
    );

    sl_ucode_store #(.SLOTS(SLOTS), .AW(AW), .IW(INSTR_W)) u_store (
        .clk         (clk),
        .run_i       (run),
        .host_we_i   (prog_we),
        .host_addr_i (prog_addr),
        .host_data_i (prog_wdata),
        .rd_addr_i   (pc),
        .rd_data_o   (ins_raw)
    );

    assign ins = uinstr_t'(ins_raw);

    sl_data_banks #(
        .DEPTH(SLOTS), .AW(AW), .DW(DW), .IN_SLOT(IN_SLOT), .OUT_SLOT(OUT_SLOT)
    ) u_banks (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_addr_a_i (ins.addr_a),
        .rd_addr_b_i (ins.addr_b),
        .rd_a_o      (rd_a),
        .rd_b_o      (rd_b),
        .we_a_i      (we_a),
        .we_b_i      (we_b),
        .wr_addr_i   (ins.addr_w),
        .wr_data_i   (result),
        .audio_wr_i  (wrap),
        .audio_in_i  (audio_in),
        .audio_tap_o (tap)
    );

    // Operand X routing.
    always_comb begin
        case (ins.src_x)
            SRC_A:   opx = rd_a;
            SRC_B:   opx = rd_b;
            SRC_EXT: opx = ext_rdata;
            default: opx = acc;
        endcase
    end

    // Operand Y routing.
    always_comb begin
        case (ins.src_y)
            SRC_A:   opy = rd_a;
            SRC_B:   opy = rd_b;
            SRC_EXT: opy = ext_rdata;
            default: opy = acc;
        endcase
    end

    sl_func_unit #(.DW(DW), .FRAC(FRAC_W)) u_fu (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .op_i     (ins.op),
        .x_i      (opx),
        .y_i      (opy),
        .result_o (result),
        .acc_o    (acc)
    );

    assign we_a      = run && (ins.dst == DST_A);
    assign we_b      = run && (ins.dst == DST_B);
    assign ext_we    = run && (ins.dst == DST_EXT);
    assign ext_waddr = ins.addr_w;
    assign ext_wdata = result;
    assign ext_raddr = ins.addr_b;

    // Output word register, refreshed once per pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            audio_out <= '0;
        end else if (wrap) begin
            audio_out <= tap;
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ins.rsvd == '0)); // R4
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !(ext_we || we_a || we_b)); // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(audio_out)); // R3
endmodule

// File: tb/tb_sl_sample_loop_core.sv
`timescale 1ns/1ps
// Bench: loads a gain-and-mix microprogram and checks each pass against
// models computed from the requirements.
module tb_sl_sample_loop_core;
    logic        clk = 1'b0;
    logic        rst_n, run, prog_we;
    logic [8:0]  prog_addr;
    logic [63:0] prog_wdata;
    logic [23:0] audio_in, audio_out;
    logic        sample_strobe;
    logic [8:0]  ext_raddr, ext_waddr;
    logic [23:0] ext_rdata, ext_wdata;
    logic        ext_we;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam int G0   = 4194304;   // 0.5
    localparam int G1   = -2097152;  // -0.25
    localparam int KOFF = 3145728;   // 0.375

    always #2 clk = ~clk;

    sl_sample_loop_core dut (
        .clk(clk), .rst_n(rst_n), .run(run), .prog_we(prog_we),
        .prog_addr(prog_addr), .prog_wdata(prog_wdata),
        .audio_in(audio_in), .audio_out(audio_out), .sample_strobe(sample_strobe),
        .ext_raddr(ext_raddr), .ext_rdata(ext_rdata), .ext_we(ext_we),
        .ext_waddr(ext_waddr), .ext_wdata(ext_wdata)
    );

    // External memory model: gains and offset at fixed addresses.
    always_comb begin
        case (ext_raddr)
            9'd5:    ext_rdata = 24'(G0);
            9'd6:    ext_rdata = 24'(G1);
            9'd8:    ext_rdata = 24'(KOFF);
            default: ext_rdata = '0;
        endcase
    end

    function automatic int clip(longint v);
        if (v > 64'sd8388607) return 8388607;
        if (v < -64'sd8388608) return -8388608;
        return int'(v);
    endfunction

    function automatic int mulq(int a, int b);
        return clip((longint'(a) * longint'(b)) >>> 23);
    endfunction

    function automatic int s24(logic [23:0] v);
        return int'($signed(v));
    endfunction

    // Output of one pass: sat(2 * sat(cur*G0 + prev*G1)).
    function automatic int model_out(int cur, int prev);
        int mix;
        mix = clip(longint'(mulq(cur, G0)) + longint'(mulq(prev, G1)));
        return clip(longint'(mix) + longint'(mix));
    endfunction

    // Word layout per R4.
    function automatic logic [63:0] mk(int a, int b, int w, int dst, int sx, int sy, int op);
        return {9'(a), 9'(b), 9'(w), 2'(dst), 2'(sx), 2'(sy), 3'(op), 28'd0};
    endfunction

    function automatic logic [63:0] prog_word(int slot);
        case (slot)
            0: return mk(0, 5, 0, 0, 0, 2, 2);   // acc = A0*G0
            1: return mk(1, 6, 7, 2, 0, 2, 3);   // B7 = acc + A1*G1
            2: return mk(0, 0, 1, 1, 0, 0, 4);   // A1 = A0
            3: return mk(0, 7, 0, 2, 1, 1, 0);   // B0 = B7 + B7
            4: return mk(0, 0, 9, 3, 1, 0, 4);   // ext[9] = B0
            5: return mk(0, 8, 10, 3, 0, 2, 1);  // ext[10] = A0 - K
            6: return mk(0, 0, 11, 3, 3, 3, 0);  // ext[11] = acc + acc
            default: return 64'd0;
        endcase
    endfunction

    function automatic int pick(int p);
        case (p)
            0: return 8388607;
            1: return -8388608;
            2: return 8388607;
            3: return 1000;
            default: return s24(24'($urandom));
        endcase
    endfunction

    task automatic chk(string req, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int cyc, ph, pass, cur, prev, nxt, sub_exp, held;
        bit stopped;
        void'($urandom(32'd2024));
        rst_n = 1'b0; run = 1'b0; prog_we = 1'b0; prog_addr = '0;
        prog_wdata = '0; audio_in = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 strobe after reset", sample_strobe == 1'b0, sample_strobe, 0);
        chk("R10 audio_out after reset", audio_out == '0, s24(audio_out), 0);
        chk("R10 ext_we after reset", ext_we == 1'b0, ext_we, 0);

        // R9: load while stopped.
        for (int i = 0; i < 512; i++) begin
            prog_we = 1'b1; prog_addr = 9'(i); prog_wdata = prog_word(i);
            @(negedge clk);
        end
        prog_we = 1'b0;

        cur = 0; prev = 0; pass = 0; stopped = 1'b0;
        nxt = pick(0); audio_in = 24'(nxt);
        run = 1'b1; cyc = 0;
        while (pass < 14) begin
            @(posedge clk); cyc++;
            @(negedge clk);
            ph = cyc % 512;
            if (ph == 0) begin
                chk("R2 strobe at wrap", sample_strobe == 1'b1, sample_strobe, 1);
                chk("R3 R6 R7 audio_out", s24(audio_out) == model_out(cur, prev),
                    s24(audio_out), model_out(cur, prev));
                chk("R5 ext_raddr slot0", ext_raddr == 9'd5, ext_raddr, 5);
                prev = cur; cur = nxt; pass++;
                nxt = pick(pass); audio_in = 24'(nxt);
            end else if (sample_strobe !== 1'b0) begin
                chk("R2 strobe off-wrap", 1'b0, sample_strobe, 0);
            end
            if (ph == 4) begin
                // R1 R8: slot 4 executes four cycles after the strobe cycle.
                chk("R8 ext_we slot4", ext_we == 1'b1 && ext_waddr == 9'd9, ext_waddr, 9);
                chk("R8 ext_wdata slot4", s24(ext_wdata) == model_out(cur, prev),
                    s24(ext_wdata), model_out(cur, prev));
            end else if (ph == 5) begin
                sub_exp = clip(longint'(cur) - longint'(KOFF));
                chk("R6 subtract", ext_we && s24(ext_wdata) == sub_exp, s24(ext_wdata), sub_exp);
                chk("R5 ext_raddr slot5", ext_raddr == 9'd8, ext_raddr, 8);
            end else if (ph == 6) begin
                sub_exp = clip(2 * longint'(clip(longint'(cur) - longint'(KOFF))));
                chk("R5 accumulator source", ext_we && s24(ext_wdata) == sub_exp,
                    s24(ext_wdata), sub_exp);
            end else if (ext_we !== 1'b0) begin
                chk("R8 ext_we idle slot", 1'b0, ext_we, 0);
            end
            if (pass == 5 && ph == 200) begin
                // R9: write while running must be ignored.
                prog_we = 1'b1; prog_addr = 9'd3; prog_wdata = mk(0, 0, 0, 2, 0, 0, 4);
                @(posedge clk); cyc++;
                @(negedge clk);
                prog_we = 1'b0;
            end
            if (pass == 9 && ph == 100 && !stopped) begin
                stopped = 1'b1;
                run = 1'b0;
                held = s24(audio_out);
                for (int k = 0; k < 30; k++) begin
                    @(posedge clk);
                    @(negedge clk);
                    chk("R9 no strobe stopped", sample_strobe == 1'b0, sample_strobe, 0);
                    chk("R9 no ext write stopped", ext_we == 1'b0, ext_we, 0);
                    chk("R9 audio_out held", s24(audio_out) == held, s24(audio_out), held);
                end
                prev = cur;   // slot 2 already copied A0 into A1
                run = 1'b1; cyc = 0;
            end
        end
        finish_run();
    end
endmodule